// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is a synchronous memory with independent read and write paths. It models a double-data-rate SRAM with one data beat per clock cycle. Clock cycles alternate between a command slot and a data slot, counted from the first rising edge after reset release. A read request and a write request can both be taken in the same command slot. Each request carries a command address one bit narrower than the beat-level depth. Every access moves exactly two beats: the even beat address first, then the odd one.

Write data and its per-byte enable mask are sampled beat by beat in the two cycles after the write command. A completed write is parked in a pending entry and goes into the array only when the next write completes. Read data leaves a fixed-latency pipeline with a per-beat valid strobe, which stands in for an echo clock. Reads always see every write commanded in the same or an earlier command slot, whether that write is still collecting data, pending or already stored.

An output-timing select lets the output register run either every cycle or only on cycles flagged by an output tick.

Top module: `sio_b2_sram`

## Requirements
- R1: Each read returns two beats in consecutive cycles: first the word at beat address {cmd_addr, 0}, then the word at {cmd_addr, 1}. Each write stores two beats at the same two beat addresses.
- R2: Command edges are edges 0, 2, 4, … counted from the first rising edge after rst_ni goes high. At the other edges, rd_i, wr_i and the addresses have no effect.
- R3: For a write commanded at edge k, beat 0 (wdata_i, wbe_i) is sampled at edge k+1 and beat 1 at edge k+2. wbe_i[j]=1 enables byte j, which is wdata_i[8j+7:8j], of that beat only.
- R4: With out_sel_i=0, a read commanded at edge k shows beat 0 on rdata_o after edge k+2*RD_LAT and beat 1 after edge k+2*RD_LAT+1, with rvalid_o=1 in both cycles. In every other cycle rvalid_o=0, and rdata_o is zero whenever rvalid_o is 0.
- R5: A read returns the effect of all writes commanded at the same or an earlier command edge, and of no write commanded later.
- R6: Bytes whose wbe_i bit is 0 keep their previous contents.
- R7: A read and a write in the same command slot to different addresses are both carried out.
- R8: With out_sel_i=1, rdata_o and rvalid_o update only at edges where oclk_tick_i=1 and hold otherwise. With oclk_tick_i=1 at every edge, the timing matches out_sel_i=0.
- R9: While rst_ni is low, rvalid_o=0 and rdata_o=0.
- R10: Reads in every command slot give an unbroken stream of beats, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read request (command slot) |
| rd_addr_i | input | AW | Read command address |
| wr_i | input | 1 | Write request (command slot) |
| wr_addr_i | input | AW | Write command address |
| wdata_i | input | DW | Write data beat |
| wbe_i | input | DW/8 | Byte enables for the current write beat |
| out_sel_i | input | 1 | 1: output register gated by oclk_tick_i |
| oclk_tick_i | input | 1 | Output-stage enable when out_sel_i=1 |
| rdata_o | output | DW | Read data beat |
| rvalid_o | output | 1 | Beat strobe for rdata_o |

## Verification
A faulty forwarding compare or a faulty merge priority shows up as wrong bytes on rdata_o exactly RD_LAT command slots after a read that overlaps an in-flight write. A pending entry that is lost or committed twice shows up on the next read of that address, and the random sweep reaches that read within a few slots. A write-collector phase that is off by one slot shifts bytes between beats or takes the odd-slot junk, and a later read shows this. A fault in the output pipeline or the slot counter moves or drops rvalid_o, and the latency check sees that in the first read burst.

// File: rtl/sio_b2_pkg.sv
`timescale 1ns/1ps
package sio_b2_pkg;
  localparam int unsigned BURST_LEN = 2;
  typedef enum logic {BEAT_EVEN = 1'b0, BEAT_ODD = 1'b1} beat_e;
endpackage

// File: rtl/sio_b2_wcollect.sv
`timescale 1ns/1ps
module sio_b2_wcollect
  import sio_b2_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned NB = DW / 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmd_slot_i,
  input  logic                             wr_i,
  input  logic [AW-1:0]                    wr_addr_i,
  input  logic [DW-1:0]                    wdata_i,
  input  logic [NB-1:0]                    wbe_i,
  output logic                             fw_v_o,
  output logic [AW-1:0]                    fw_addr_o,
  output logic [BURST_LEN-1:0][DW-1:0]     fw_data_o,
  output logic [BURST_LEN-1:0][NB-1:0]     fw_be_o,
  output logic                             pend_v_o,
  output logic [AW-1:0]                    pend_addr_o,
  output logic [BURST_LEN-1:0][DW-1:0]     pend_data_o,
  output logic [BURST_LEN-1:0][NB-1:0]     pend_be_o,
  output logic                             commit_o
);
  logic          wait_b0_q, wait_b1_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] d0_q;
  logic [NB-1:0] be0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_b0_q   <= 1'b0;
      wait_b1_q   <= 1'b0;
      addr_q      <= '0;
      d0_q        <= '0;
      be0_q       <= '0;
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
      pend_be_o   <= '0;
    end else if (cmd_slot_i) begin
      wait_b0_q <= wr_i;
      wait_b1_q <= 1'b0;
      if (wr_i) addr_q <= wr_addr_i;
      // beat 1 arrives with the next command slot; older pending entry retires
      if (wait_b1_q) begin
        pend_v_o    <= 1'b1;
        pend_addr_o <= addr_q;
        pend_data_o <= {wdata_i, d0_q};
        pend_be_o   <= {wbe_i, be0_q};
      end
    end else if (wait_b0_q) begin
      wait_b0_q <= 1'b0;
      wait_b1_q <= 1'b1;
      d0_q      <= wdata_i;
      be0_q     <= wbe_i;
    end
  end

  assign fw_v_o    = wait_b1_q;
  assign fw_addr_o = addr_q;
  assign fw_data_o = {wdata_i, d0_q};
  assign fw_be_o   = {wbe_i, be0_q};
  assign commit_o  = cmd_slot_i & wait_b1_q & pend_v_o;

  p_beat0_in_data_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_b0_q |-> !cmd_slot_i);
  p_beat1_in_cmd_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_b1_q |-> cmd_slot_i);
  p_beat_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_b1_q |-> $past(wait_b0_q));
endmodule

// File: rtl/sio_b2_array.sv
`timescale 1ns/1ps
module sio_b2_array
  import sio_b2_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned NB = DW / 8
) (
  input  logic                         clk_i,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [BURST_LEN-1:0][DW-1:0] wr_data_i,
  input  logic [BURST_LEN-1:0][NB-1:0] wr_be_i,
  input  logic [AW-1:0]                rd_addr_i,
  input  logic                         fa_v_i,
  input  logic [AW-1:0]                fa_addr_i,
  input  logic [BURST_LEN-1:0][DW-1:0] fa_data_i,
  input  logic [BURST_LEN-1:0][NB-1:0] fa_be_i,
  input  logic                         fb_v_i,
  input  logic [AW-1:0]                fb_addr_i,
  input  logic [BURST_LEN-1:0][DW-1:0] fb_data_i,
  input  logic [BURST_LEN-1:0][NB-1:0] fb_be_i,
  output logic [BURST_LEN-1:0][DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic hit_a, hit_b;
  assign hit_a = fa_v_i && (fa_addr_i == rd_addr_i);
  assign hit_b = fb_v_i && (fb_addr_i == rd_addr_i);

  // bank b holds beat address {cmd_addr, b}
  for (genvar b = 0; b < BURST_LEN; b++) begin : g_bank
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] raw;

    always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
        for (int j = 0; j < NB; j++) begin
          if (wr_be_i[b][j]) mem_q[wr_addr_i][8*j +: 8] <= wr_data_i[b][8*j +: 8];
        end
      end
    end

    assign raw = mem_q[rd_addr_i];

    // youngest write wins per byte, then pending entry, then array
    for (genvar j = 0; j < NB; j++) begin : g_byte
      assign rd_data_o[b][8*j +: 8] =
        (hit_a && fa_be_i[b][j]) ? fa_data_i[b][8*j +: 8] :
        (hit_b && fb_be_i[b][j]) ? fb_data_i[b][8*j +: 8] :
                                   raw[8*j +: 8];
    end
  end
endmodule

// File: rtl/sio_b2_rdpipe.sv
`timescale 1ns/1ps
module sio_b2_rdpipe
  import sio_b2_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_slot_i,
  input  logic                         stage_en_i,
  input  logic                         rq_v_i,
  input  logic [BURST_LEN-1:0][DW-1:0] rq_data_i,
  output logic [DW-1:0]                rdata_o,
  output logic                         rvalid_o
);
  logic                         src_v;
  logic [BURST_LEN-1:0][DW-1:0] src_d;
  logic                         hold_v_q;
  logic [DW-1:0]                hold_d_q;
  beat_e                        rbeat_q;

  if (RD_LAT == 1) begin : g_direct
    assign src_v = rq_v_i;
    assign src_d = rq_data_i;
  end else begin : g_stages
    localparam int unsigned NS = RD_LAT - 1;
    logic                         v_q [NS];
    logic [BURST_LEN-1:0][DW-1:0] d_q [NS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NS; i++) v_q[i] <= 1'b0;
      end else if (cmd_slot_i) begin
        v_q[0] <= rq_v_i;
        for (int i = 1; i < NS; i++) v_q[i] <= v_q[i-1];
      end
    end

    always_ff @(posedge clk_i) begin
      if (cmd_slot_i) begin
        d_q[0] <= rq_data_i;
        for (int i = 1; i < NS; i++) d_q[i] <= d_q[i-1];
      end
    end

    assign src_v = v_q[NS-1];
    assign src_d = d_q[NS-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
    end else if (cmd_slot_i) begin
      hold_v_q <= src_v;
      hold_d_q <= src_d[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rbeat_q  <= BEAT_EVEN;
    end else if (stage_en_i) begin
      if (cmd_slot_i) begin
        rvalid_o <= src_v;
        rdata_o  <= src_v ? src_d[0] : '0;
        rbeat_q  <= BEAT_EVEN;
      end else begin
        rvalid_o <= hold_v_q;
        rdata_o  <= hold_v_q ? hold_d_q : '0;
        rbeat_q  <= BEAT_ODD;
      end
    end
  end

  p_two_beats_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_slot_i && stage_en_i && $past(stage_en_i) && rvalid_o && rbeat_q == BEAT_EVEN)
      |=> (rvalid_o && rbeat_q == BEAT_ODD));
  p_idle_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));
endmodule

// File: rtl/sio_b2_sram.sv
`timescale 1ns/1ps
module sio_b2_sram
  import sio_b2_pkg::*;
#(
  parameter int unsigned AW     = 4,
  parameter int unsigned DW     = 16,
  parameter int unsigned RD_LAT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wbe_i,
  input  logic            out_sel_i,
  input  logic            oclk_tick_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o
);
  localparam int unsigned NB = DW / 8;

  logic          cmd_slot_q;
  logic          rq_v_q;
  logic [AW-1:0] rq_addr_q;
  logic          stage_en;

  logic                         fw_v, pend_v, commit;
  logic [AW-1:0]                fw_addr, pend_addr;
  logic [BURST_LEN-1:0][DW-1:0] fw_data, pend_data, merged;
  logic [BURST_LEN-1:0][NB-1:0] fw_be, pend_be;

  // 1: next edge is a command edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_slot_q <= 1'b1;
    else         cmd_slot_q <= !cmd_slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_v_q    <= 1'b0;
      rq_addr_q <= '0;
    end else if (cmd_slot_q) begin
      rq_v_q    <= rd_i;
      rq_addr_q <= rd_addr_i;
    end
  end

  assign stage_en = out_sel_i ? oclk_tick_i : 1'b1;

  sio_b2_wcollect #(.AW(AW), .DW(DW), .NB(NB)) u_wcol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_slot_i  (cmd_slot_q),
    .wr_i        (wr_i),
    .wr_addr_i   (wr_addr_i),
    .wdata_i     (wdata_i),
    .wbe_i       (wbe_i),
    .fw_v_o      (fw_v),
    .fw_addr_o   (fw_addr),
    .fw_data_o   (fw_data),
    .fw_be_o     (fw_be),
    .pend_v_o    (pend_v),
    .pend_addr_o (pend_addr),
    .pend_data_o (pend_data),
    .pend_be_o   (pend_be),
    .commit_o    (commit)
  );

  sio_b2_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (commit),
    .wr_addr_i (pend_addr),
    .wr_data_i (pend_data),
    .wr_be_i   (pend_be),
    .rd_addr_i (rq_addr_q),
    .fa_v_i    (fw_v),
    .fa_addr_i (fw_addr),
    .fa_data_i (fw_data),
    .fa_be_i   (fw_be),
    .fb_v_i    (pend_v),
    .fb_addr_i (pend_addr),
    .fb_data_i (pend_data),
    .fb_be_i   (pend_be),
    .rd_data_o (merged)
  );

  sio_b2_rdpipe #(.DW(DW), .RD_LAT(RD_LAT)) u_rdpipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_slot_i (cmd_slot_q),
    .stage_en_i (stage_en),
    .rq_v_i     (rq_v_q),
    .rq_data_i  (merged),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sel_i && !oclk_tick_i) |=> ($stable(rdata_o) && $stable(rvalid_o)));
  p_capture_cmd_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_slot_q |=> ($stable(rq_v_q) && $stable(rq_addr_q)));
endmodule

// File: tb/sio_b2_sram_tb_top.sv
`timescale 1ns/1ps
module sio_b2_sram_tb_top;
  localparam int AW = 4, DW = 16, NB = 2, LAT = 2, NP = 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rd, wr, osel, tick, rvalid;
  logic [AW-1:0] ra, wa;
  logic [DW-1:0] wdata, rdata;
  logic [NB-1:0] wbe;

  sio_b2_sram #(.AW(AW), .DW(DW), .RD_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .rd_addr_i(ra), .wr_i(wr),
    .wr_addr_i(wa), .wdata_i(wdata), .wbe_i(wbe), .out_sel_i(osel),
    .oclk_tick_i(tick), .rdata_o(rdata), .rvalid_o(rvalid));

  bit            c_rd [NP], c_wr [NP], c_junk [NP], c_osel [NP], c_todd [NP];
  logic [AW-1:0] c_ra [NP], c_wa [NP];
  logic [DW-1:0] c_d0 [NP], c_d1 [NP], e0 [NP], e1 [NP];
  logic [NB-1:0] c_b0 [NP], c_b1 [NP];
  string         c_tag [NP];
  logic [DW-1:0] refm [2**(AW+1)];
  int np = 0, nvec = 0, nfail = 0;
  bit done = 0;

  function automatic logic [DW-1:0] gen(int p, int b);
    return DW'((p * 40503 + b * 977 + 17) ^ (p << 7));
  endfunction

  task automatic add(input bit r, input int a_r, input bit w, input int a_w,
                     input logic [NB-1:0] m0, input logic [NB-1:0] m1,
                     input bit junk, input bit os, input bit td, input string tag);
    c_rd[np] = r;   c_ra[np] = AW'(a_r);
    c_wr[np] = w;   c_wa[np] = AW'(a_w);
    c_b0[np] = m0;  c_b1[np] = m1;
    c_d0[np] = gen(np, 0); c_d1[np] = gen(np, 1);
    c_junk[np] = junk; c_osel[np] = os; c_todd[np] = td; c_tag[np] = tag;
    np++;
  endtask

  task automatic chk(input string tag, input logic gv, input logic ev,
                     input logic [DW-1:0] gd, input logic [DW-1:0] ed);
    nvec++;
    if (gv !== ev || gd !== ed) begin
      nfail++;
      $display("FAIL %s: got rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h", tag, gv, gd, ev, ed);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL R4 watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic          ev, pv;
    logic [DW-1:0] ed, pd;
    string         tg;
    logic [31:0]   x;

    rst_n = 0; rd = 0; wr = 0; ra = '0; wa = '0; wdata = '0; wbe = '0; osel = 0; tick = 1;

    // R1: fill and read back every address
    for (int a = 0; a < 16; a++) add(0, 0, 1, a, 2'b11, 2'b11, 0, 0, 1, "R1");
    for (int a = 0; a < 16; a++) add(1, a, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R1");
    // R5: same-slot, write-then-read, read-then-later-write
    add(1, 3, 1, 3, 2'b11, 2'b11, 0, 0, 1, "R5");
    add(1, 7, 1, 7, 2'b01, 2'b10, 0, 0, 1, "R5");
    add(0, 0, 1, 5, 2'b11, 2'b11, 0, 0, 1, "R5");
    add(1, 5, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R5");
    add(1, 6, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R5");
    add(0, 0, 1, 6, 2'b11, 2'b11, 0, 0, 1, "R5");
    add(1, 6, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R5");
    // R3: distinct masks per beat, read while pending and after commit
    add(0, 0, 1, 11, 2'b10, 2'b01, 0, 0, 1, "R3");
    add(1, 11, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R3");
    add(1, 11, 1, 12, 2'b11, 2'b11, 0, 0, 1, "R3");
    add(0, 0, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R3");
    add(1, 11, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R3");
    // R6: masked bytes retained
    add(1, 2, 1, 2, 2'b01, 2'b10, 0, 0, 1, "R6");
    add(1, 2, 1, 2, 2'b00, 2'b00, 0, 0, 1, "R6");
    add(0, 0, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R6");
    add(0, 0, 1, 4, 2'b11, 2'b11, 0, 0, 1, "R6");
    add(1, 2, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R6");
    // R7: simultaneous read and write, different addresses
    add(1, 0, 1, 15, 2'b11, 2'b11, 0, 0, 1, "R7");
    add(1, 15, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R7");
    add(1, 0, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R7");
    // R2: requests in data slots must be ignored
    for (int i = 0; i < 8; i++) add(1, i * 2, i % 2, i + 1, 2'b11, 2'b11, 1, 0, 1, "R2");
    for (int a = 0; a < 16; a++) add(1, a, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R2");
    // R10: reads in every slot mixed with random writes and masks
    x = 32'h1234_5671;
    for (int i = 0; i < 160; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      add(1, int'(x[19:16]), x[20], int'(x[24:21]), x[26:25], x[28:27], x[29], 0, 1, "R10");
    end
    // R8: gated output stage
    for (int i = 0; i < 12; i++)
      add(1, i, (i % 3) == 0, (i + 5) % 16, 2'b11, 2'b01, 0, 1, (i % 3) != 1, "R8");
    for (int i = 0; i < LAT + 2; i++) add(0, 0, 0, 0, 2'b11, 2'b11, 0, 0, 1, "R4");

    // reference model: writes of a slot land before that slot's read
    for (int p = 0; p < np; p++) begin
      if (c_wr[p]) for (int j = 0; j < NB; j++) begin
        if (c_b0[p][j]) refm[{c_wa[p], 1'b0}][8*j +: 8] = c_d0[p][8*j +: 8];
        if (c_b1[p][j]) refm[{c_wa[p], 1'b1}][8*j +: 8] = c_d1[p][8*j +: 8];
      end
      if (c_rd[p]) begin
        e0[p] = refm[{c_ra[p], 1'b0}];
        e1[p] = refm[{c_ra[p], 1'b1}];
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", rvalid, 1'b0, rdata, '0);
    rst_n = 1;
    pv = 0; pd = '0;

    for (int q = 0; q < np; q++) begin
      // command slot
      rd = c_rd[q]; ra = c_ra[q]; wr = c_wr[q]; wa = c_wa[q];
      if (q > 0 && c_wr[q-1]) begin wdata = c_d1[q-1]; wbe = c_b1[q-1]; end
      else begin wdata = gen(q + 999, 1); wbe = '1; end
      osel = c_osel[q]; tick = 1;
      @(posedge clk); @(negedge clk);
      if (q >= LAT && c_rd[q-LAT]) begin ev = 1; ed = e0[q-LAT]; tg = c_tag[q-LAT]; end
      else begin ev = 0; ed = '0; tg = "R4"; end
      chk(tg, rvalid, ev, rdata, ed);
      pv = ev; pd = ed;
      // data slot
      rd = c_junk[q]; wr = c_junk[q]; ra = c_ra[q] ^ 4'h8; wa = c_wa[q] ^ 4'h5;
      if (c_wr[q]) begin wdata = c_d0[q]; wbe = c_b0[q]; end
      else begin wdata = gen(q + 777, 0); wbe = '1; end
      tick = c_todd[q];
      @(posedge clk); @(negedge clk);
      if (c_osel[q] && !c_todd[q]) begin ev = pv; ed = pd; tg = "R8"; end
      else if (q >= LAT && c_rd[q-LAT]) begin ev = 1; ed = e1[q-LAT]; tg = c_tag[q-LAT]; end
      else begin ev = 0; ed = '0; tg = "R4"; end
      chk(tg, rvalid, ev, rdata, ed);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule